// File: doc/BRIEF.md
# UART FIFO Control Register with Transmit and Receive Queues

This block holds the write-only control byte of a UART's FIFO section and the two character queues it governs. The host writes one byte to it. That byte turns the queues on or off, flushes either queue, chooses how the two active-low ready outputs behave, and picks the receive occupancy at which an interrupt is raised. When the queues are on, each one holds up to `DEPTH` characters. When they are off, each path acts as a one-character holding register.

The host pushes transmit characters and pops receive characters. The serial shifters, which are outside this block, pop transmit characters and push received ones. Both queues report their occupancy and a sticky overrun flag. The active-low ready outputs follow either the single-character rule or the block-transfer (DMA) rule.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, `fifo_on` is 0, both counts are 0, both overrun flags are 0, `rx_trig_irq` is 0, `rxrdy_n` is 1 and `txrdy_n` is 0.
- R2: A control write with bit 0 clear sets `fifo_on` to 0 on the next edge. It flushes neither queue, even when bit 1 or bit 2 is set, so the held occupancy stays.
- R3: A control write with bit 0 set sets `fifo_on`, takes bit 3 as the DMA-mode select and bits 7:6 as the trigger code. Bits 5:4 have no effect.
- R4: A control write with bits 0 and 1 set empties the receive queue and clears its overrun flag at that edge. The flush does not persist, so a later write with bit 1 clear leaves the receive contents alone.
- R5: A control write with bits 0 and 2 set empties the transmit queue and clears its overrun flag at that edge. The receive queue is untouched.
- R6: When `fifo_on` is 1, each queue stores up to `DEPTH` (16) characters. It returns them in the order they were pushed, and its count tracks every accepted push and pop.
- R7: A push into a full queue with no pop in the same cycle is dropped. The count does not change and the overrun flag sets, and the flag stays set until that queue is flushed.
- R8: A pop from an empty queue leaves the count at 0 and the read data unchanged.
- R9: When `fifo_on` is 0, each queue holds one character. A second push without a pop is dropped and raises overrun.
- R10: `rx_trig_irq` is 1 exactly while the receive count is at least the trigger level. Trigger code 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. The level is 1 whenever `fifo_on` is 0.
- R11: In normal mode (bit 3 = 0), `rxrdy_n` is 0 while the receive count is nonzero, and `txrdy_n` is 0 only while the transmit count is 0.
- R12: In DMA mode (bit 3 = 1), `rxrdy_n` is 0 while the receive count is at least the trigger level, and `txrdy_n` is 0 while the transmit queue is not full.
- R13: A push together with a pop on a full queue is accepted with no overrun. A flush in the same cycle as a push discards that push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| tx_push | input | 1 | Host pushes a transmit character |
| tx_wdata | input | DW | Transmit character in |
| tx_pop | input | 1 | Transmit shifter pops a character |
| tx_rdata | output | DW | Last character popped from the transmit queue |
| tx_count | output | $clog2(DEPTH+1) | Transmit occupancy |
| tx_overrun | output | 1 | Sticky transmit overrun flag |
| rx_push | input | 1 | Receive shifter pushes a character |
| rx_wdata | input | DW | Received character in |
| rx_pop | input | 1 | Host pops a received character |
| rx_rdata | output | DW | Last character popped from the receive queue |
| rx_count | output | $clog2(DEPTH+1) | Receive occupancy |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| fifo_on | output | 1 | Queues enabled |
| rx_trig_irq | output | 1 | Receive trigger interrupt |
| txrdy_n | output | 1 | Active-low transmit ready |
| rxrdy_n | output | 1 | Active-low receive ready |

## Verification
Two collisions get the most attention. The first is a flush issued in the same cycle as a push, on the same queue. The bench provokes it by asserting `rx_push` on the edge where a control write sets bits 0 and 1, and it expects a count of zero afterwards. The second is a push and a pop on the same edge while the queue is full. The bench provokes it after filling the queue to 16, and it expects the count to stay at 16, the overrun flag to stay clear, and the oldest character to appear on the read data.

// File: rtl/uart_fcr_pkg.sv
package uart_fcr_pkg;

  localparam int FCR_W       = 8;
  localparam int BIT_ON      = 0;
  localparam int BIT_RXFLUSH = 1;
  localparam int BIT_TXFLUSH = 2;
  localparam int BIT_DMA     = 3;
  localparam int TRIG_LO     = 6;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_QTR  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_NEAR = 2'b11
  } trig_sel_e;

  typedef struct packed {
    logic      on;
    logic      dma;
    trig_sel_e trig;
  } fcr_cfg_t;

  // Trigger occupancy as a fraction of the queue depth.
  function automatic int unsigned trig_level(trig_sel_e t, int unsigned depth);
    case (t)
      TRIG_ONE:  return 1;
      TRIG_QTR:  return depth / 4;
      TRIG_HALF: return depth / 2;
      default:   return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/ufc_rst_sync.sv
module ufc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/ufc_cfg_reg.sv
module ufc_cfg_reg
  import uart_fcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [FCR_W-1:0] wdata,
  output fcr_cfg_t         cfg,
  output logic             rx_flush,
  output logic             tx_flush
);

  fcr_cfg_t cfg_q, cfg_d;
  logic     unused_rsvd;

  assign unused_rsvd = ^wdata[5:4];

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.on = wdata[BIT_ON];
      if (wdata[BIT_ON]) begin
        cfg_d.dma  = wdata[BIT_DMA];
        cfg_d.trig = trig_sel_e'(wdata[TRIG_LO+1:TRIG_LO]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '{on: 1'b0, dma: 1'b0, trig: TRIG_ONE};
    else if (we) cfg_q <= cfg_d;
  end

  // Flush strobes exist only during the write cycle: self-clearing.
  assign rx_flush = we & wdata[BIT_ON] & wdata[BIT_RXFLUSH];
  assign tx_flush = we & wdata[BIT_ON] & wdata[BIT_TXFLUSH];
  assign cfg      = cfg_q;

endmodule

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       deep,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       overrun
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d, cap;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          ovf_q, ovf_d;
  logic          room, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    cap     = deep ? CW'(DEPTH) : CW'(1);
    room    = cnt_q < cap;
    do_pop  = pop && (cnt_q != '0) && !flush;
    do_push = push && !flush && (room || (do_pop && cnt_q == cap));
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    cnt_d   = cnt_q;
    rdata_d = rdata_q;
    ovf_d   = ovf_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
      ovf_d  = 1'b0;
    end else begin
      if (do_push) wptr_d = ptr_next(wptr_q);
      if (do_pop) begin
        rptr_d  = ptr_next(rptr_q);
        rdata_d = mem[rptr_q];
      end
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
      if (push && !do_push) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      rdata_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

  assign rdata   = rdata_q;
  assign count   = cnt_q;
  assign full    = !room;
  assign overrun = ovf_q;

endmodule

// File: rtl/ufc_ready.sv
module ufc_ready
  import uart_fcr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  fcr_cfg_t                   cfg,
  input  logic [$clog2(DEPTH+1)-1:0] rx_count,
  input  logic [$clog2(DEPTH+1)-1:0] tx_count,
  input  logic                       tx_full,
  output logic                       rx_trig_irq,
  output logic                       rxrdy_n,
  output logic                       txrdy_n
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] level;
  logic          at_trig;

  always_comb begin
    level   = cfg.on ? CW'(trig_level(cfg.trig, DEPTH)) : CW'(1);
    at_trig = rx_count >= level;
    rx_trig_irq = at_trig;
    if (cfg.dma) begin
      rxrdy_n = !at_trig;
      txrdy_n = tx_full;
    end else begin
      rxrdy_n = (rx_count == '0);
      txrdy_n = (tx_count != '0);
    end
  end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fcr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [7:0]                 cfg_wdata,
  input  logic                       tx_push,
  input  logic [DW-1:0]              tx_wdata,
  input  logic                       tx_pop,
  output logic [DW-1:0]              tx_rdata,
  output logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic                       tx_overrun,
  input  logic                       rx_push,
  input  logic [DW-1:0]              rx_wdata,
  input  logic                       rx_pop,
  output logic [DW-1:0]              rx_rdata,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic                       rx_overrun,
  output logic                       fifo_on,
  output logic                       rx_trig_irq,
  output logic                       txrdy_n,
  output logic                       rxrdy_n
);

  fcr_cfg_t cfg;
  logic     rst_n_int, rx_flush, tx_flush, tx_full, rx_full_unused;

  ufc_rst_sync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ufc_cfg_reg reg_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .cfg      (cfg),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  ufc_fifo #(.DW(DW), .DEPTH(DEPTH)) tx_q_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .deep    (cfg.on),
    .flush   (tx_flush),
    .push    (tx_push),
    .wdata   (tx_wdata),
    .pop     (tx_pop),
    .rdata   (tx_rdata),
    .count   (tx_count),
    .full    (tx_full),
    .overrun (tx_overrun)
  );

  ufc_fifo #(.DW(DW), .DEPTH(DEPTH)) rx_q_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .deep    (cfg.on),
    .flush   (rx_flush),
    .push    (rx_push),
    .wdata   (rx_wdata),
    .pop     (rx_pop),
    .rdata   (rx_rdata),
    .count   (rx_count),
    .full    (rx_full_unused),
    .overrun (rx_overrun)
  );

  ufc_ready #(.DEPTH(DEPTH)) rdy_i (
    .cfg         (cfg),
    .rx_count    (rx_count),
    .tx_count    (tx_count),
    .tx_full     (tx_full),
    .rx_trig_irq (rx_trig_irq),
    .rxrdy_n     (rxrdy_n),
    .txrdy_n     (txrdy_n)
  );

  assign fifo_on = cfg.on;

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_we,
  input logic [7:0]                 cfg_wdata,
  input logic                       rx_push,
  input logic                       rx_pop,
  input logic [DW-1:0]              rx_rdata,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic                       rx_overrun,
  input logic [$clog2(DEPTH+1)-1:0] tx_count,
  input logic                       tx_overrun,
  input logic                       fifo_on,
  input logic                       rx_trig_irq,
  input logic                       rxrdy_n
);

  logic rx_fl, tx_fl;
  assign rx_fl = cfg_we && cfg_wdata[0] && cfg_wdata[1];
  assign tx_fl = cfg_we && cfg_wdata[0] && cfg_wdata[2];

  assert_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_wdata[0] |=> !fifo_on);

  assert_rx_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fl |=> (rx_count == '0) && !rx_overrun);

  assert_tx_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fl |=> (tx_count == '0) && !tx_overrun);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= DEPTH) && (tx_count <= DEPTH));

  assert_overrun_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !rx_pop && fifo_on && (rx_count == DEPTH) && !rx_fl
    |=> rx_overrun && (rx_count == DEPTH));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && !rx_fl |=> rx_overrun);

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && !rx_push && (rx_count == '0) && !rx_fl
    |=> $stable(rx_rdata) && (rx_count == '0));

  assert_irq_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_trig_irq |-> (rx_count != '0));

  assert_rxrdy_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rxrdy_n |-> (rx_count != '0));

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DW(DW), .DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .rx_push     (rx_push),
  .rx_pop      (rx_pop),
  .rx_rdata    (rx_rdata),
  .rx_count    (rx_count),
  .rx_overrun  (rx_overrun),
  .tx_count    (tx_count),
  .tx_overrun  (tx_overrun),
  .fifo_on     (fifo_on),
  .rx_trig_irq (rx_trig_irq),
  .rxrdy_n     (rxrdy_n)
);

// File: tb/uart_fifo_ctrl_tb_top.sv
module uart_fifo_ctrl_tb_top;

  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [7:0]    cfg_wdata;
  logic          tx_push, tx_pop, rx_push, rx_pop;
  logic [DW-1:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_overrun, rx_overrun, fifo_on, rx_trig_irq, txrdy_n, rxrdy_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  uart_fifo_ctrl #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_count(tx_count), .tx_overrun(tx_overrun),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_count(rx_count), .rx_overrun(rx_overrun),
    .fifo_on(fifo_on), .rx_trig_irq(rx_trig_irq), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] d);
    rx_push = 1'b1; rx_wdata = d;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic rx_get();
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic tx_put(input logic [7:0] d);
    tx_push = 1'b1; tx_wdata = d;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic tx_get();
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  function automatic int lvl_of(input int t);
    return (t == 0) ? 1 : (t == 1) ? DEPTH / 4 : (t == 2) ? DEPTH / 2 : DEPTH - 2;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    tx_wdata = '0; rx_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 fifo_on", int'(fifo_on), 0);
    check("R1 rx_count", int'(rx_count), 0);
    check("R1 tx_count", int'(tx_count), 0);
    check("R1 overrun", int'(rx_overrun) + int'(tx_overrun), 0);
    check("R1 irq", int'(rx_trig_irq), 0);
    check("R1 rxrdy_n", int'(rxrdy_n), 1);
    check("R1 txrdy_n", int'(txrdy_n), 0);

    // R3/R6/R7/R8/R10/R11/R12: sweep trigger codes and both ready modes on receive
    for (int dma = 0; dma < 2; dma++) begin
      for (int t = 0; t < 4; t++) begin
        wr(8'((t << 6) | 8'h30 | (dma << 3) | 8'h07)); // reserved bits 5:4 set, R3
        check("R3 fifo_on", int'(fifo_on), 1);
        check("R4 flushed", int'(rx_count), 0);
        for (int n = 1; n <= DEPTH; n++) begin
          rx_put(8'(8'h40 + n));
          check("R6 rx_count", int'(rx_count), n);
          check("R10 irq", int'(rx_trig_irq), (n >= lvl_of(t)) ? 1 : 0);
          if (dma == 1) check("R12 rxrdy_n", int'(rxrdy_n), (n >= lvl_of(t)) ? 0 : 1);
          else          check("R11 rxrdy_n", int'(rxrdy_n), 0);
        end
        rx_put(8'hEE);
        check("R7 count held", int'(rx_count), DEPTH);
        check("R7 overrun", int'(rx_overrun), 1);
        for (int n = 1; n <= DEPTH; n++) begin
          rx_get();
          check("R6 order", int'(rx_rdata), 8'h40 + n);
        end
        check("R7 sticky", int'(rx_overrun), 1);
        rx_get();
        check("R8 rdata held", int'(rx_rdata), 8'h40 + DEPTH);
        check("R8 count", int'(rx_count), 0);
      end
    end

    // R5/R11/R12 transmit sweep
    for (int dma = 0; dma < 2; dma++) begin
      wr(8'(8'h05 | (dma << 3)));
      check("R5 tx flushed", int'(tx_count), 0);
      check("R5 tx overrun", int'(tx_overrun), 0);
      for (int n = 1; n <= DEPTH; n++) begin
        tx_put(8'(8'h80 + n));
        check("R6 tx_count", int'(tx_count), n);
        if (dma == 1) check("R12 txrdy_n", int'(txrdy_n), (n == DEPTH) ? 1 : 0);
        else          check("R11 txrdy_n", int'(txrdy_n), 1);
      end
      tx_get();
      check("R6 tx order", int'(tx_rdata), 8'h81);
    end

    // R5 leaves receive alone; R4 flush does not persist
    wr(8'h01);
    rx_put(8'h11); rx_put(8'h12);
    wr(8'h05);
    check("R5 rx untouched", int'(rx_count), 2);
    check("R5 tx emptied", int'(tx_count), 0);
    wr(8'h01);
    check("R4 no persist", int'(rx_count), 2);

    // R2: disable write with flush bits set does not flush
    wr(8'h06);
    check("R2 fifo_on", int'(fifo_on), 0);
    check("R2 rx kept", int'(rx_count), 2);

    // R9: holding register when disabled
    wr(8'h07);
    wr(8'h00);
    rx_put(8'hA1);
    check("R9 count", int'(rx_count), 1);
    check("R10 irq off-mode", int'(rx_trig_irq), 1);
    rx_put(8'hA2);
    check("R9 drop", int'(rx_count), 1);
    check("R9 overrun", int'(rx_overrun), 1);
    rx_get();
    check("R9 data", int'(rx_rdata), 8'hA1);

    // R13: push and pop together on a full queue
    wr(8'h03);
    for (int n = 0; n < DEPTH; n++) rx_put(8'(8'h20 + n));
    rx_push = 1'b1; rx_pop = 1'b1; rx_wdata = 8'h5A;
    @(negedge clk);
    rx_push = 1'b0; rx_pop = 1'b0;
    check("R13 count", int'(rx_count), DEPTH);
    check("R13 no overrun", int'(rx_overrun), 0);
    check("R13 oldest", int'(rx_rdata), 8'h20);

    // R13: flush coincident with push
    rx_push = 1'b1; rx_wdata = 8'h77;
    wr(8'h03);
    rx_push = 1'b0;
    check("R13 flush wins", int'(rx_count), 0);
    check("R4 overrun clr", int'(rx_overrun), 0);

    finish_run();
  end

endmodule